// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a periodic tick source that sits beside a processor core on a small word-addressed register bus. A 24-bit counter steps down once per selected tick. After it reaches zero, the next tick reloads it from a programmable reload register. The step from one to zero is the "wrap" event. Each wrap sets a sticky count flag. It can also raise a level interrupt request that a core or bench watches.

Ticks come from one of two sources: the core clock itself, or rising edges of an external reference strobe that is resynchronised into the core clock domain. A debug-halt input freezes the count. A calibration register reports a 24-bit interval value taken from input pins, together with a presence bit.

Software brings the timer up in four steps: clear the control register, program the reload value, write anything to the current-value register to zero the counter, and then set the enable bit.

Top module: `tick_timer`

## Requirements
- R1: While the enable bit (control bit 0) is 1, each tick lowers the counter by exactly one. While the enable bit is 0, the counter holds its value.
- R2: A tick that finds the counter at zero loads the reload value. With core-clock ticks and reload N, the counter therefore repeats the sequence N, N-1, …, 1, 0 every N+1 cycles.
- R3: The count flag is control/status bit 16. It becomes 1 on each step of the counter from one to zero. A read of the control/status register returns the flag and then clears it. If a wrap occurs in the same cycle as the read, the flag stays set.
- R4: A write of any value to the current-value register (offset 0x8) sets the counter to zero and clears both the count flag and the interrupt request.
- R5: When the interrupt-enable bit (control bit 1) is 1, a wrap drives `irqOut` high. `irqOut` stays high until the control/status register is read, the current-value register is written, or the interrupt-enable bit is cleared. When the bit is 0, a wrap sets only the flag.
- R6: Control bit 2 selects the tick source. A value of 1 selects the core clock. A value of 0 selects `refClkIn`, where each rising edge, after a two-flop synchronizer, gives exactly one tick.
- R7: While `dbgHalt` is 1, the counter does not change.
- R8: The calibration register (offset 0xC) reads `calibValue` in bits 23:0 and `calibPresent` in bit 31. Writes to it are ignored.
- R9: With a reload value of zero, the counter stays at zero. Neither the count flag nor the interrupt request is ever set.
- R10: The register offsets are: control/status at 0x0, reload at 0x4, current value at 0x8. Reserved bits read as zero, and the reload register keeps 24 bits. An access whose address has nonzero bits 1:0 is ignored and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe for one cycle |
| busRdEn | input | 1 | Read strobe for one cycle; the flag is cleared at the end of that cycle |
| busWrData | input | 24 | Write data; only the bits a register stores are carried |
| busRdData | output | 32 | Read data, valid in the cycle busRdEn is high |
| refClkIn | input | 1 | External reference strobe, asynchronous |
| dbgHalt | input | 1 | Debug halt; freezes the counter |
| calibValue | input | 24 | Calibration interval value |
| calibPresent | input | 1 | High when calibValue is valid |
| irqOut | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is the reference-strobe path. There, the count moves only several cycles after each strobe edge, and a missed or doubled edge shows up only as an off-by-one in the current value. The bench produces isolated strobe pulses several cycles wide and waits out the synchronizer latency before each read. It then compares the result with one decrement per pulse, and also confirms that long stretches with no pulse leave the counter untouched. The other awkward case is making the interrupt clear on a status read without a wrap landing in the same cycle. The bench avoids that collision by timing the read against the known reload period.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // register select, taken from address bits 3:2
  typedef enum logic [1:0] {
    SEL_CSR     = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_CALIB   = 2'd3
  } regSel_e;

  localparam int EN_BIT   = 0;
  localparam int IE_BIT   = 1;
  localparam int SRC_BIT  = 2;
  localparam int FLAG_BIT = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic enable;   // counting allowed
    logic useCore;  // 1: core clock ticks, 0: reference edges
    logic clrCnt;   // force counter to zero this cycle
  } cntCtl_t;
endpackage

// File: rtl/tick_dp.sv
module tick_dp
  import tick_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtl_t          ctl,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             refIn,
  input  logic             dbgHalt,
  output logic [CNT_W-1:0] count,
  output logic             hitZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] refPipe;
  logic refPrev;
  logic refRise;
  logic tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPipe <= '0;
      refPrev <= 1'b0;
    end else begin
      refPipe <= {refPipe[SYNC_STAGES-2:0], refIn};
      refPrev <= refPipe[SYNC_STAGES-1];
    end
  end

  assign refRise = refPipe[SYNC_STAGES-1] & ~refPrev;
  assign tick    = ctl.enable & ~dbgHalt & (ctl.useCore | refRise);
  assign hitZero = tick & ~ctl.clrCnt & (count == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.clrCnt) begin
      count <= '0;
    end else if (tick) begin
      count <= (count == '0) ? reloadVal : count - ONE;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrCnt |=> (count == '0)); // R4
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (dbgHalt && !ctl.clrCnt) |=> $stable(count)); // R7
  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count == '0 && !ctl.clrCnt) |=> (count == $past(reloadVal))); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count != '0 && !ctl.clrCnt) |=> (count == $past(count) - ONE)); // R1
  AST_EXT_WAITS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.useCore && !refRise && !ctl.clrCnt) |=> $stable(count)); // R6
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  count,
  input  logic              hitZero,
  input  logic [CNT_W-1:0]  calibValue,
  input  logic              calibPresent,
  output cntCtl_t           ctl,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              irqOut
);
  regSel_e sel;
  logic addrOk;
  logic wrCsr, rdCsr, wrReload, wrCurrent;
  logic enBit, ieBit, srcBit, cntFlag, irqPend, ieNext;
  logic [CNT_W-1:0] reloadReg;

  assign sel       = regSel_e'(busAddr[3:2]);
  assign addrOk    = (busAddr[1:0] == 2'b00) && ((busAddr >> 4) == '0);
  assign wrCsr     = busWrEn && addrOk && (sel == SEL_CSR);
  assign rdCsr     = busRdEn && addrOk && (sel == SEL_CSR);
  assign wrReload  = busWrEn && addrOk && (sel == SEL_RELOAD);
  assign wrCurrent = busWrEn && addrOk && (sel == SEL_CURRENT);
  assign ieNext    = wrCsr ? busWrData[IE_BIT] : ieBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      ieBit     <= 1'b0;
      srcBit    <= 1'b0;
      reloadReg <= '0;
    end else begin
      if (wrCsr) begin
        enBit  <= busWrData[EN_BIT];
        ieBit  <= busWrData[IE_BIT];
        srcBit <= busWrData[SRC_BIT];
      end
      if (wrReload) reloadReg <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntFlag <= 1'b0;
      irqPend <= 1'b0;
    end else begin
      if (wrCurrent)    cntFlag <= 1'b0;
      else if (hitZero) cntFlag <= 1'b1;
      else if (rdCsr)   cntFlag <= 1'b0;

      if (wrCurrent || !ieNext)  irqPend <= 1'b0;
      else if (hitZero && ieBit) irqPend <= 1'b1;
      else if (rdCsr)            irqPend <= 1'b0;
    end
  end

  assign ctl.enable  = enBit;
  assign ctl.useCore = srcBit;
  assign ctl.clrCnt  = wrCurrent;
  assign reloadVal   = reloadReg;
  assign irqOut      = irqPend;

  always_comb begin
    busRdData = '0;
    if (busRdEn && addrOk) begin
      unique case (sel)
        SEL_CSR: begin
          busRdData[EN_BIT]   = enBit;
          busRdData[IE_BIT]   = ieBit;
          busRdData[SRC_BIT]  = srcBit;
          busRdData[FLAG_BIT] = cntFlag;
        end
        SEL_RELOAD:  busRdData[CNT_W-1:0] = reloadReg;
        SEL_CURRENT: busRdData[CNT_W-1:0] = count;
        SEL_CALIB: begin
          busRdData[CNT_W-1:0]  = calibValue;
          busRdData[DATA_W-1]   = calibPresent;
        end
        default: busRdData = '0;
      endcase
    end
  end

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ieBit); // R5
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (hitZero && !wrCurrent) |=> cntFlag); // R3
  AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdCsr && !hitZero) |=> !cntFlag); // R3
  AST_CURRENT_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrCurrent |=> (!cntFlag && !irqOut)); // R4
  AST_RELOAD_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (reloadReg == '0 && count == '0) |-> !hitZero); // R9
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              refClkIn,
  input  logic              dbgHalt,
  input  logic [CNT_W-1:0]  calibValue,
  input  logic              calibPresent,
  output logic              irqOut
);
  cntCtl_t ctl;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] count;
  logic hitZero;

  tick_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .count(count), .hitZero(hitZero),
    .calibValue(calibValue), .calibPresent(calibPresent),
    .ctl(ctl), .reloadVal(reloadVal), .irqOut(irqOut)
  );

  tick_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reloadVal(reloadVal),
    .refIn(refClkIn), .dbgHalt(dbgHalt),
    .count(count), .hitZero(hitZero)
  );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [23:0] busWrData = '0;
  logic [31:0] busRdData;
  logic refClkIn = 1'b0;
  logic dbgHalt = 1'b0;
  logic [23:0] calibValue = 24'h0F4240;
  logic calibPresent = 1'b1;
  logic irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_CSR = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

  always #5 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .refClkIn(refClkIn), .dbgHalt(dbgHalt), .calibValue(calibValue),
    .calibPresent(calibPresent), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic regWrite(input logic [3:0] a, input logic [23:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [23:0] rld, input logic [23:0] ctrlVal);
    regWrite(A_CSR, 24'h0);
    regWrite(A_RLD, rld);
    regWrite(A_CUR, 24'h0);
    regWrite(A_CSR, ctrlVal);
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(A_CSR, v); check("R10 reset csr", v, 32'h0);
    regRead(A_RLD, v); check("R10 reset reload", v, 32'h0);
    regRead(A_CUR, v); check("R10 reset current", v, 32'h0);
    check("R5 reset irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testCoreSequence();
    logic [31:0] v;
    logic [31:0] exp [8] = '{0, 5, 4, 3, 2, 1, 0, 5};
    setup(24'd5, 24'h5);
    for (int i = 0; i < 8; i++) begin
      regRead(A_CUR, v);
      check("R1 R2 core countdown", v, exp[i]);
    end
    regWrite(A_CSR, 24'h0);
  endtask

  task automatic testFlag();
    logic [31:0] v;
    setup(24'd3, 24'h5);
    idle(4);
    check("R5 no irq with ie=0", {31'b0, irqOut}, 32'h0);
    regWrite(A_CSR, 24'h0);
    regRead(A_CSR, v); check("R3 flag set after wrap", v, 32'h0001_0000);
    regRead(A_CSR, v); check("R3 flag cleared by read", v, 32'h0);
  endtask

  task automatic testCurrentClear();
    logic [31:0] v;
    setup(24'd2, 24'h5);
    idle(3);
    regWrite(A_CSR, 24'h0);
    regWrite(A_CUR, 24'hABCDEF);
    regRead(A_CUR, v); check("R4 current cleared", v, 32'h0);
    regRead(A_CSR, v); check("R4 flag cleared by current write", v, 32'h0);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    setup(24'd3, 24'h7);
    idle(3);
    check("R5 irq low before wrap", {31'b0, irqOut}, 32'h0);
    idle(1);
    check("R5 irq high on wrap", {31'b0, irqOut}, 32'h1);
    idle(5);
    check("R5 irq level held", {31'b0, irqOut}, 32'h1);
    regRead(A_CSR, v); check("R3 R5 csr with flag", v, 32'h0001_0007);
    check("R5 irq cleared by csr read", {31'b0, irqOut}, 32'h0);
    regWrite(A_CSR, 24'h0);
  endtask

  task automatic testHalt();
    logic [31:0] v1, v2, v3;
    setup(24'd100, 24'h5);
    idle(5);
    dbgHalt = 1'b1;
    regRead(A_CUR, v1);
    idle(10);
    regRead(A_CUR, v2); check("R7 halt freezes", v2, v1);
    dbgHalt = 1'b0;
    idle(3);
    regRead(A_CUR, v3); check("R7 resumes after halt", v3, v1 - 3);
  endtask

  task automatic testDisabled();
    logic [31:0] v1, v2;
    regWrite(A_CSR, 24'h0);
    regRead(A_CUR, v1);
    idle(10);
    regRead(A_CUR, v2); check("R1 disabled holds", v2, v1);
  endtask

  task automatic refPulse();
    refClkIn = 1'b1; idle(4);
    refClkIn = 1'b0; idle(4);
  endtask

  task automatic testExtRef();
    logic [31:0] v;
    setup(24'd50, 24'h1);
    idle(12);
    regRead(A_CUR, v); check("R6 no ticks without ref edges", v, 32'h0);
    refPulse(); refPulse(); refPulse();
    idle(4);
    regRead(A_CUR, v); check("R6 one tick per ref edge", v, 32'd48);
    idle(20);
    regRead(A_CUR, v); check("R6 stable with ref idle", v, 32'd48);
    regWrite(A_CSR, 24'h0);
  endtask

  task automatic testReloadZero();
    logic [31:0] v;
    setup(24'd0, 24'h7);
    idle(20);
    regRead(A_CUR, v); check("R9 stays at zero", v, 32'h0);
    check("R9 no irq", {31'b0, irqOut}, 32'h0);
    regRead(A_CSR, v); check("R9 no flag", v, 32'h7);
  endtask

  task automatic testMapAndCalib();
    logic [31:0] v;
    regWrite(A_CSR, 24'hFFFFFF);
    regRead(A_CSR, v); check("R10 csr reserved bits zero", v, 32'h7);
    regWrite(A_CSR, 24'h0);
    regWrite(A_RLD, 24'hFFFFFF);
    regRead(A_RLD, v); check("R10 reload 24 bits", v, 32'h00FF_FFFF);
    regWrite(4'h5, 24'h000123);
    regRead(A_RLD, v); check("R10 misaligned write ignored", v, 32'h00FF_FFFF);
    regRead(4'h5, v); check("R10 misaligned read zero", v, 32'h0);
    regWrite(A_CAL, 24'h000001);
    regRead(A_CAL, v); check("R8 calibration present", v, 32'h800F_4240);
    calibPresent = 1'b0; calibValue = 24'h00ABCD;
    regRead(A_CAL, v); check("R8 calibration absent", v, 32'h0000_ABCD);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testCoreSequence();
    testFlag();
    testCurrentClear();
    testIrq();
    testHalt();
    testDisabled();
    testExtRef();
    testReloadZero();
    testMapAndCalib();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule